// File: doc/BRIEF.md
# Local interrupt controller register file

This block holds the software-visible configuration registers of a local interrupt controller. It occupies a 4 KB address window in which every register starts on a 16-byte boundary. It decodes each access and applies that register's own write rule. Some registers are read-only. Some keep only certain bits, and some force bits to one. The six vector table entries keep two bits that software cannot change. The error status register only takes effect on every second write.

An access is presented for one cycle with `acc_valid`, together with its direction, a byte address, four byte enables and write data. Writes take effect at the clock edge that samples the access. Read data and the error pulse appear in the cycle that follows. An undecoded offset, or an access whose bytes would run past the 32-bit register, is rejected: it changes nothing, returns zero and pulses `acc_err`.

The software-enable bit is copied from the spurious vector register and driven out on `sw_enable`. The error status arming flag is driven out on `esr_armed`.

Top module: `lic_regfile`

## Requirements
- R1: Address bits [11:4] select a register slot. The decoded slots are:
  - 0x02 identity, 0x03 version, 0x08 task priority
  - 0x0D logical destination, 0x0E destination format, 0x0F spurious vector
  - 0x28 error status
  - 0x32 to 0x37 the six vector table entries
  - 0x38 initial count, 0x39 current count, 0x3E divide configuration

  Any other slot, or a non-zero address bits [3:2], is an error access.
- R2: Byte enable bit i addresses register byte `acc_addr[1:0] + i`. If any enabled byte would land at byte position 4 or higher, the access is an error.
- R3: An error access leaves every register and both state bits unchanged. In the next cycle it gives `acc_err` = 1 and `acc_rdata` = 0. `acc_err` is 0 in every other cycle.
- R4: A write replaces only the enabled bytes of the register, with write data byte i placed at register byte `acc_addr[1:0] + i`. The register's rule is then applied to the merged word. A read returns the register value shifted right by 8 × `acc_addr[1:0]`.
- R5: The identity and task priority registers keep bits 7:0 of the merged word and read zero above bit 7.
- R6: The version register always reads the `VERSION` parameter. The current count register always reads zero. Writes to either have no effect.
- R7: The logical destination register keeps only bits 31:24. The destination format register stores the merged word with bits 27:0 forced to one, and it resets to 0xFFFFFFFF.
- R8: Each of the six vector table entries resets to `LVT_INIT`. On a write, bits 12 and 14 keep their previous value and every other bit takes the merged value.
- R9: The spurious vector register stores the merged word. `sw_enable` takes bit 8 of that merged word in the cycle after the write. `sw_enable` resets to 0.
- R10: A write to the error status register while `esr_armed` is 0 sets `esr_armed` and leaves the register unchanged. A write while `esr_armed` is 1 clears `esr_armed` and clears the register. The register resets to zero.
- R11: A legal read of the error status register clears `esr_armed`.
- R12: The initial count register stores all 32 bits. The divide configuration register keeps only bits 3, 1 and 0.
- R13: A write is visible to a read issued in the next cycle. When `acc_valid` is 0 or the access is a write, `acc_rdata` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Byte address within the window |
| acc_be | input | 4 | Byte enables relative to acc_addr |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, one cycle after the access |
| acc_err | output | 1 | One-cycle pulse for a rejected access |
| sw_enable | output | 1 | Software-enable bit taken from the spurious vector register |
| esr_armed | output | 1 | Error status arming flag |

## Verification
The bench targets the error status handshake: arm, then clear, then a read clearing the arm flag, plus an error access aimed at that register while it is armed. A design that toggled the flag on reads, or on rejected accesses, would show the wrong `esr_armed` on the next cycle.

The vector entries are written with all ones and with all zeros. This exposes a design that lets bits 12 and 14 through, or that loses their reset value. Offset byte-enable writes, and writes that run just past byte 3, catch a merge that is shifted the wrong way or a span check that is missing. Either fault would show up as a corrupted initial count or a missing error pulse.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int WIN_AW = 12;
  localparam int DW     = 32;
  localparam int NBYTE  = DW / 8;
  localparam int SH_W   = $clog2(NBYTE);
  localparam int NLVT   = 6;
  localparam int NREG   = 16;
  localparam int IDX_W  = $clog2(NREG);

  typedef enum logic [IDX_W-1:0] {
    RI_ID, RI_VER, RI_TPR, RI_LDR, RI_DFR, RI_SVR, RI_ESR,
    RI_LVT0, RI_LVT1, RI_LVT2, RI_LVT3, RI_LVT4, RI_LVT5,
    RI_INIT, RI_CUR, RI_DIV
  } reg_idx_e;

  localparam logic [DW-1:0] LVT_RO_MASK = 32'h0000_5000;
  localparam logic [DW-1:0] DFR_ONES    = 32'h0FFF_FFFF;
  localparam logic [DW-1:0] LDR_KEEP    = 32'hFF00_0000;
  localparam logic [DW-1:0] BYTE0_KEEP  = 32'h0000_00FF;
  localparam logic [DW-1:0] DIV_KEEP    = 32'h0000_000B;
endpackage

// File: rtl/lic_decode.sv
module lic_decode
  import lic_pkg::*;
(
  input  logic [WIN_AW-1:0] addr,
  input  logic [NBYTE-1:0]  be,
  output reg_idx_e          idx,
  output logic              legal,
  output logic [SH_W-1:0]   shift,
  output logic [NBYTE-1:0]  lane_mask
);
  localparam int LANE_W = 2 * NBYTE - 1;

  logic [WIN_AW-5:0] slot;
  logic              hit;
  logic [LANE_W-1:0] lanes;

  assign slot  = addr[WIN_AW-1:4];
  assign shift = addr[SH_W-1:0];
  assign lanes = {{(LANE_W-NBYTE){1'b0}}, be} << shift;
  assign lane_mask = lanes[NBYTE-1:0];

  always_comb begin
    hit = 1'b1;
    idx = RI_ID;
    case (slot)
      8'h02: idx = RI_ID;
      8'h03: idx = RI_VER;
      8'h08: idx = RI_TPR;
      8'h0D: idx = RI_LDR;
      8'h0E: idx = RI_DFR;
      8'h0F: idx = RI_SVR;
      8'h28: idx = RI_ESR;
      8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37:
        idx = reg_idx_e'(IDX_W'(slot[2:0]) + IDX_W'(5));
      8'h38: idx = RI_INIT;
      8'h39: idx = RI_CUR;
      8'h3E: idx = RI_DIV;
      default: hit = 1'b0;
    endcase
  end

  assign legal = hit && (addr[3:SH_W] == '0) && (lanes[LANE_W-1:NBYTE] == '0);
endmodule

// File: rtl/lic_policy.sv
module lic_policy
  import lic_pkg::*;
(
  input  reg_idx_e        idx,
  input  logic [DW-1:0]   old_val,
  input  logic [DW-1:0]   merged,
  input  logic            armed,
  output logic [DW-1:0]   new_val
);
  always_comb begin
    new_val = merged;
    case (idx)
      RI_ID, RI_TPR: new_val = merged & BYTE0_KEEP;
      RI_VER, RI_CUR: new_val = old_val;
      RI_LDR:        new_val = merged & LDR_KEEP;
      RI_DFR:        new_val = merged | DFR_ONES;
      RI_ESR:        new_val = armed ? '0 : old_val;
      RI_LVT0, RI_LVT1, RI_LVT2, RI_LVT3, RI_LVT4, RI_LVT5:
        new_val = (merged & ~LVT_RO_MASK) | (old_val & LVT_RO_MASK);
      RI_DIV:        new_val = merged & DIV_KEEP;
      default:       new_val = merged;
    endcase
  end
endmodule

// File: rtl/lic_esr_arm.sv
module lic_esr_arm (
  input  logic clk,
  input  logic srst_n,
  input  logic wr_hit,
  input  logic rd_hit,
  output logic armed
);
  logic arm_d, arm_q;

  always_comb begin
    arm_d = arm_q;
    if (wr_hit)      arm_d = ~arm_q;
    else if (rd_hit) arm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) arm_q <= 1'b0;
    else         arm_q <= arm_d;
  end

  assign armed = arm_q;
endmodule

// File: rtl/lic_regfile.sv
module lic_regfile
  import lic_pkg::*;
#(
  parameter logic [31:0] VERSION  = 32'h0005_0014,
  parameter logic [31:0] LVT_INIT = 32'h0001_4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [WIN_AW-1:0] acc_addr,
  input  logic [NBYTE-1:0]  acc_be,
  input  logic [DW-1:0]     acc_wdata,
  output logic [DW-1:0]     acc_rdata,
  output logic              acc_err,
  output logic              sw_enable,
  output logic              esr_armed
);
  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  reg_idx_e          idx;
  logic              legal;
  logic [SH_W-1:0]   shift;
  logic [NBYTE-1:0]  lane_mask;

  lic_decode u_dec (
    .addr(acc_addr), .be(acc_be), .idx(idx), .legal(legal),
    .shift(shift), .lane_mask(lane_mask)
  );

  logic acc_ok, wr_ok, rd_ok, bad;
  assign acc_ok = acc_valid && legal;
  assign wr_ok  = acc_ok && acc_write;
  assign rd_ok  = acc_ok && !acc_write;
  assign bad    = acc_valid && !legal;

  logic [DW-1:0] regs_q [NREG];
  logic [DW-1:0] regs_d [NREG];
  logic [DW-1:0] old_val, wdata_al, merged, new_val;

  assign old_val  = regs_q[idx];
  assign wdata_al = acc_wdata << {shift, 3'b000};

  for (genvar b = 0; b < NBYTE; b++) begin : g_merge
    assign merged[8*b +: 8] = lane_mask[b] ? wdata_al[8*b +: 8] : old_val[8*b +: 8];
  end

  lic_policy u_pol (
    .idx(idx), .old_val(old_val), .merged(merged),
    .armed(esr_armed), .new_val(new_val)
  );

  lic_esr_arm u_arm (
    .clk(clk), .srst_n(srst_n),
    .wr_hit(wr_ok && (idx == RI_ESR)),
    .rd_hit(rd_ok && (idx == RI_ESR)),
    .armed(esr_armed)
  );

  function automatic logic [DW-1:0] init_val(input int k);
    if (k == int'(RI_VER))                               return VERSION;
    if (k == int'(RI_DFR))                               return '1;
    if (k >= int'(RI_LVT0) && k < int'(RI_LVT0) + NLVT) return LVT_INIT;
    return '0;
  endfunction

  always_comb begin
    for (int k = 0; k < NREG; k++) regs_d[k] = regs_q[k];
    if (wr_ok) regs_d[idx] = new_val;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      for (int k = 0; k < NREG; k++) regs_q[k] <= init_val(k);
    end else begin
      for (int k = 0; k < NREG; k++) regs_q[k] <= regs_d[k];
    end
  end

  logic          swen_d, swen_q, err_d, err_q;
  logic [DW-1:0] rdata_d, rdata_q;

  always_comb begin
    swen_d  = swen_q;
    if (wr_ok && (idx == RI_SVR)) swen_d = merged[8];
    rdata_d = rd_ok ? (old_val >> {shift, 3'b000}) : '0;
    err_d   = bad;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      swen_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      swen_q  <= swen_d;
      err_q   <= err_d;
      rdata_q <= rdata_d;
    end
  end

  assign acc_rdata = rdata_q;
  assign acc_err   = err_q;
  assign sw_enable = swen_q;
endmodule

// File: rtl/lic_regfile_chk.sv
module lic_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid,
  input logic        write,
  input logic [11:0] addr,
  input logic [3:0]  be,
  input logic [31:0] rdata,
  input logic        err,
  input logic        sw_en,
  input logic        armed
);
  logic esr_wr, esr_rd;
  assign esr_wr = valid && write  && (addr == 12'h280);
  assign esr_rd = valid && !write && (addr == 12'h280);

  assert_err_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (rdata == 32'h0));

  assert_arm_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (esr_wr && !armed) |=> armed);

  assert_arm_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (esr_wr && armed) |=> !armed);

  assert_read_disarm_R11: assert property (@(posedge clk) disable iff (!rst_n)
    esr_rd |=> !armed);

  assert_swen_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sw_en) |-> $past(valid && write && (addr[11:4] == 8'h0F)));

  assert_id_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !write && (addr == 12'h020)) |=> (rdata[31:8] == 24'h0));

  assert_undecoded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (addr[11:4] == 8'h00)) |=> err);

  assert_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (addr[1:0] == 2'd3) && be[1]) |=> err);
endmodule

bind lic_regfile lic_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .valid(acc_valid), .write(acc_write),
  .addr(acc_addr), .be(acc_be), .rdata(acc_rdata), .err(acc_err),
  .sw_en(sw_enable), .armed(esr_armed)
);

// File: tb/sim_lic_regfile.sv
`timescale 1ns/1ps
module sim_lic_regfile;
  localparam logic [31:0] VER  = 32'h0005_0014;
  localparam logic [31:0] LVTI = 32'h0001_4000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [3:0]  acc_be = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        acc_err, sw_enable, esr_armed;

  always #10 clk = ~clk;

  lic_regfile #(.VERSION(VER), .LVT_INIT(LVTI)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_be(acc_be), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_err(acc_err), .sw_enable(sw_enable),
    .esr_armed(esr_armed)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] mreg [int];
  bit          marm, msw;
  logic [31:0] exp_rd;
  bit          exp_err;
  string       cur_tag = "R13";

  function automatic bit known(input int s);
    return s inside {8'h02, 8'h03, 8'h08, 8'h0D, 8'h0E, 8'h0F, 8'h28,
                     [8'h32:8'h37], 8'h38, 8'h39, 8'h3E};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    mreg.delete();
    for (int s = 0; s < 256; s++) if (known(s)) mreg[s] = 32'h0;
    mreg[8'h03] = VER;
    mreg[8'h0E] = 32'hFFFF_FFFF;
    for (int s = 8'h32; s <= 8'h37; s++) mreg[s] = LVTI;
    marm = 0; msw = 0; exp_rd = 0; exp_err = 0;
  endtask

  task automatic cyc(input bit v, input bit w, input logic [11:0] a,
                     input logic [3:0] be, input logic [31:0] d, input string tag);
    int s, sh;
    logic [6:0]  lanes;
    logic [31:0] old, m, dal, nv;
    bit ok;
    @(negedge clk);
    check(cur_tag, "rdata", acc_rdata, exp_rd);
    check(cur_tag, "err", {31'h0, acc_err}, {31'h0, exp_err});
    check(cur_tag, "armed", {31'h0, esr_armed}, {31'h0, marm});
    check(cur_tag, "sw_enable", {31'h0, sw_enable}, {31'h0, msw});
    acc_valid = v; acc_write = w; acc_addr = a; acc_be = be; acc_wdata = d;
    cur_tag = tag;
    s = int'(a[11:4]); sh = int'(a[1:0]);
    lanes = {3'b0, be} << sh;
    ok = known(s) && (a[3:2] == 2'b00) && (lanes[6:4] == 3'b000);
    exp_rd = 0; exp_err = 0;
    if (!v) return;
    if (!ok) begin exp_err = 1; return; end
    old = mreg[s];
    if (!w) begin
      exp_rd = old >> (8 * sh);
      if (s == 8'h28) marm = 0;
      return;
    end
    dal = d << (8 * sh);
    for (int b = 0; b < 4; b++) m[8*b +: 8] = lanes[b] ? dal[8*b +: 8] : old[8*b +: 8];
    nv = m;
    if (s == 8'h02 || s == 8'h08) nv = m & 32'hFF;
    else if (s == 8'h03 || s == 8'h39) nv = old;
    else if (s == 8'h0D) nv = m & 32'hFF00_0000;
    else if (s == 8'h0E) nv = m | 32'h0FFF_FFFF;
    else if (s == 8'h0F) msw = m[8];
    else if (s == 8'h28) begin
      if (marm) begin marm = 0; nv = 0; end else begin marm = 1; nv = old; end
    end
    else if (s >= 8'h32 && s <= 8'h37) nv = (m & ~32'h5000) | (old & 32'h5000);
    else if (s == 8'h3E) nv = m & 32'hB;
    mreg[s] = nv;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    cyc(1, 1, a, 4'hF, d, tag);
  endtask
  task automatic rd(input logic [11:0] a, input string tag);
    cyc(1, 0, a, 4'hF, 32'h0, tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // reset state and reset values (R1 R6 R7 R8)
    cyc(0, 0, 12'h0, 4'h0, 32'h0, "R3");
    for (int s = 0; s < 64; s++) if (known(s)) rd(12'(s << 4), "R1");
    // R5
    wr(12'h020, 32'hFFFF_FFFF, "R5"); rd(12'h020, "R5");
    wr(12'h080, 32'h1234_56A5, "R5"); rd(12'h080, "R5");
    // R6
    wr(12'h030, 32'hFFFF_FFFF, "R6"); rd(12'h030, "R6");
    wr(12'h390, 32'h1234_5678, "R6"); rd(12'h390, "R6");
    // R7
    wr(12'h0D0, 32'h1234_5678, "R7"); rd(12'h0D0, "R7");
    wr(12'h0E0, 32'h0, "R7");         rd(12'h0E0, "R7");
    wr(12'h0E0, 32'hA000_0000, "R7"); rd(12'h0E0, "R7");
    // R8
    for (int s = 8'h32; s <= 8'h37; s++) begin
      wr(12'(s << 4), 32'hFFFF_FFFF, "R8"); rd(12'(s << 4), "R8");
      wr(12'(s << 4), 32'h0, "R8");         rd(12'(s << 4), "R8");
    end
    // R9 with byte enables (R4)
    wr(12'h0F0, 32'h0000_0100, "R9"); rd(12'h0F0, "R9");
    cyc(1, 1, 12'h0F1, 4'h1, 32'h0000_0000, "R9"); rd(12'h0F0, "R9");
    cyc(1, 1, 12'h0F1, 4'h1, 32'h0000_0003, "R9");
    // R10 R11
    wr(12'h280, 32'hFFFF_FFFF, "R10"); rd(12'h280, "R11");
    wr(12'h280, 32'h1, "R10"); wr(12'h280, 32'h1, "R10"); rd(12'h280, "R10");
    wr(12'h280, 32'h1, "R10");
    cyc(1, 1, 12'h283, 4'h3, 32'h0, "R3");
    cyc(1, 0, 12'h2C0, 4'hF, 32'h0, "R3");
    cyc(0, 0, 12'h0, 4'h0, 32'h0, "R10");
    rd(12'h280, "R11");
    // R12
    wr(12'h3E0, 32'hFFFF_FFFF, "R12"); rd(12'h3E0, "R12");
    wr(12'h380, 32'hDEAD_BEEF, "R12"); rd(12'h380, "R12");
    // R4 byte merge and shifted reads
    cyc(1, 1, 12'h381, 4'h1, 32'h0000_0055, "R4"); rd(12'h380, "R4");
    cyc(1, 0, 12'h382, 4'h3, 32'h0, "R4");
    cyc(1, 1, 12'h380, 4'h9, 32'h1122_3344, "R4"); rd(12'h380, "R4");
    cyc(1, 1, 12'h380, 4'h0, 32'hFFFF_FFFF, "R4"); rd(12'h380, "R4");
    // R1 R2 R3 errors, then unchanged state
    wr(12'h000, 32'hFFFF_FFFF, "R1");
    wr(12'h040, 32'hFFFF_FFFF, "R1");
    rd(12'h3F0, "R1");
    wr(12'h384, 32'hFFFF_FFFF, "R1");
    wr(12'hFF0, 32'hFFFF_FFFF, "R1");
    cyc(1, 1, 12'h383, 4'h3, 32'hFFFF_FFFF, "R2");
    cyc(1, 1, 12'h382, 4'h4, 32'hFFFF_FFFF, "R2");
    cyc(1, 0, 12'h381, 4'h8, 32'h0, "R2");
    cyc(1, 1, 12'h0F2, 4'h2, 32'h0, "R2");
    cyc(1, 1, 12'h383, 4'h1, 32'h0000_00AB, "R4");
    rd(12'h380, "R3"); rd(12'h0F0, "R3");
    // R13 back to back
    wr(12'h080, 32'h0000_0042, "R13"); rd(12'h080, "R13");
    cyc(0, 0, 12'h080, 4'hF, 32'h0, "R13");
    cyc(0, 0, 12'h0, 4'h0, 32'h0, "R13");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule